// File: doc/BRIEF.md
# RAW10 Pixel Depacker, Two-Lane Word Stream

This block sits after a camera-serial-link packet unpacker. Its input is a stream of 16-bit payload words, one byte from each of two lanes, qualified by a valid flag. The payload carries 10-bit pixels in packed form: every five consecutive bytes hold four pixels. The first four bytes of a group carry the upper eight bits of each pixel. The fifth byte gathers the two least significant bits of all four. The block rebuilds the four pixels of each group and presents them together on a 40-bit bus with a one-cycle valid strobe.

Five bytes do not fill a whole number of 2-byte words, so a group ends in the middle of its third word. The block keeps the spare byte and uses it as the first byte of the next group. A repeating cycle of five input words therefore yields exactly two output groups. A frame-sync input restarts this cycle and drops any partly collected bytes, so that the next valid word always opens a fresh group.

Top module: `raw10_depack_top`

## Requirements
- R1: While reset is low at a clock edge, `pix_out` becomes all zeros and `pix_vld` becomes 0.
- R2: Counting valid words since reset or since the last sync, `pix_vld` pulses high for one cycle right after the 3rd word of each five-word cycle. The group it presents is bytes 0 to 4 of that cycle.
- R3: `pix_vld` also pulses right after the 5th word of each cycle. That group is the high byte of the 3rd word followed by the four bytes of the 4th and 5th words.
- R4: Within an input word, bits [7:0] are the earlier stream byte and bits [15:8] the later one.
- R5: Output pixel i (i = 0..3) sits in `pix_out[10i+9:10i]`. Its bits [9:2] come from group byte i, and its bits [1:0] come from bits [2i+1:2i] of group byte 4.
- R6: Cycles with `word_vld` low do not move the phase, add no bytes and raise no `pix_vld`, however long the gap.
- R7: When `frame_sync` is high at an edge, the phase and any held bytes are cleared. A word presented in that same cycle is discarded. The next valid word becomes byte pair 0/1 of a new group.
- R8: When `pix_vld` is low, `pix_out` keeps its previous value. Two pulses of `pix_vld` are never in adjacent cycles.
- R9: Output latency is one clock: `pix_vld` is high in the cycle after the completing word is accepted, and never without such a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| word_in | input | 16 | Payload word; low byte earlier in the stream |
| word_vld | input | 1 | Qualifies `word_in` for this cycle |
| frame_sync | input | 1 | Restarts the group phase and drops held bytes |
| pix_out | output | 40 | Four rebuilt 10-bit pixels, pixel 0 in the lowest bits |
| pix_vld | output | 1 | One-cycle strobe marking a new `pix_out` |

## Verification
The stimulus is built to expose errors at the half-word seam. The second group of each cycle starts with the spare high byte of the 3rd word. A design that dropped or reused that byte would shift every pixel of that group by one byte, and the scoreboard would catch it. Idle gaps are inserted between words at varying points in the cycle. A design that stepped its phase on every clock instead of on every valid word would emit pulses at the wrong time or mix bytes from different groups. Frame sync is applied in the middle of a group, and also together with a valid word. A design that kept its stale phase or held byte, or that accepted the word arriving with sync, would misplace the following group. Fifth-byte values such as 0xE4, 0x00 and 0xFF pin each 2-bit field to its own pixel, so a swapped or reversed field order shows up directly.

// File: rtl/raw10_depack_pkg.sv
// Package: shared constants and types for the RAW10 depacker.
// Assumes two lanes of eight bits, ten-bit pixels, four pixels per group.
package raw10_depack_pkg;

    parameter int unsigned BYTE_W      = 8;
    parameter int unsigned LANES       = 2;
    parameter int unsigned PIX_W       = 10;
    parameter int unsigned PIX_PER_GRP = 4;

    localparam int unsigned LSB_W      = PIX_W - BYTE_W;
    localparam int unsigned GRP_BYTES  = PIX_PER_GRP + 1;
    localparam int unsigned WORD_W     = LANES * BYTE_W;
    localparam int unsigned OUT_W      = PIX_PER_GRP * PIX_W;
    localparam int unsigned HOLD_BYTES = GRP_BYTES - 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [GRP_BYTES-1:0] group_t;
    typedef byte_t [HOLD_BYTES-1:0] hold_t;

    // Five valid words per cycle; two groups end in PH_A2 and PH_B1.
    typedef enum logic [2:0] {
        PH_A0 = 3'd0,
        PH_A1 = 3'd1,
        PH_A2 = 3'd2,
        PH_B0 = 3'd3,
        PH_B1 = 3'd4
    } phase_e;

endpackage

// File: rtl/raw10_phase_ctl.sv
// Module: raw10_phase_ctl
// Tracks where the next valid word falls inside the five-word cycle.
// Assumes frame_sync wins over word_vld in the same cycle (word discarded).
module raw10_phase_ctl
    import raw10_depack_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   word_vld,
    input  logic   frame_sync,
    output logic   take,
    output phase_e phase
);

    // Accept a word only when no restart is requested in the same cycle.
    always_comb begin
        take = word_vld && !frame_sync;
    end

    // Step the phase once per accepted word; restart on sync or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_A0;
        end else if (frame_sync) begin
            phase <= PH_A0;
        end else if (take) begin
            case (phase)
                PH_A0:   phase <= PH_A1;
                PH_A1:   phase <= PH_A2;
                PH_A2:   phase <= PH_B0;
                PH_B0:   phase <= PH_B1;
                default: phase <= PH_A0;
            endcase
        end
    end

endmodule

// File: rtl/raw10_byte_gather.sv
// Module: raw10_byte_gather
// Holds up to four earlier bytes and forms a five-byte group when the
// current word completes one. Assumes the low byte of a word is earlier.
module raw10_byte_gather
    import raw10_depack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              take,
    input  phase_e            phase,
    input  logic [WORD_W-1:0] word,
    output group_t            grp,
    output logic              grp_done
);

    hold_t hold;
    byte_t lo_b;
    byte_t hi_b;

    // Split the incoming word into its earlier and later byte.
    always_comb begin
        lo_b = word[BYTE_W-1:0];
        hi_b = word[WORD_W-1:BYTE_W];
    end

    // Store bytes by phase; in PH_A2 the high byte becomes the carried residue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (frame_sync) begin
            hold <= '0;
        end else if (take) begin
            case (phase)
                PH_A0: begin
                    hold[0] <= lo_b;
                    hold[1] <= hi_b;
                end
                PH_A1: begin
                    hold[2] <= lo_b;
                    hold[3] <= hi_b;
                end
                PH_A2: begin
                    hold[0] <= hi_b;
                end
                PH_B0: begin
                    hold[1] <= lo_b;
                    hold[2] <= hi_b;
                end
                default: begin
                    hold <= hold;
                end
            endcase
        end
    end

    // Assemble the finished group from held bytes plus the current word.
    always_comb begin
        if (phase == PH_B1) begin
            grp[0] = hold[0];
            grp[1] = hold[1];
            grp[2] = hold[2];
            grp[3] = lo_b;
            grp[4] = hi_b;
        end else begin
            grp[0] = hold[0];
            grp[1] = hold[1];
            grp[2] = hold[2];
            grp[3] = hold[3];
            grp[4] = lo_b;
        end
        grp_done = take && ((phase == PH_A2) || (phase == PH_B1));
    end

endmodule

// File: rtl/raw10_pixel_unpack.sv
// Module: raw10_pixel_unpack
// Pure combinational rearrangement of one five-byte group into four pixels.
// Assumes the last byte of the group carries all low-order bit pairs.
module raw10_pixel_unpack
    import raw10_depack_pkg::*;
(
    input  group_t            grp,
    output logic [OUT_W-1:0]  pixels
);

    localparam int unsigned LSB_BYTE = GRP_BYTES - 1;

    // One slice per pixel: high bits from its own byte, low bits from the shared byte.
    for (genvar i = 0; i < PIX_PER_GRP; i++) begin : g_pix
        always_comb begin
            pixels[i*PIX_W +: PIX_W] = {grp[i], grp[LSB_BYTE][i*LSB_W +: LSB_W]};
        end
    end

endmodule

// File: rtl/raw10_depack_top.sv
// Module: raw10_depack_top
// RAW10 depacker for a two-lane 16-bit payload stream. Emits four pixels
// per group, registered, one clock after the completing word.
// Assumes the upstream unpacker keeps words in stream order.
module raw10_depack_top
    import raw10_depack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_vld,
    input  logic              frame_sync,
    output logic [OUT_W-1:0]  pix_out,
    output logic              pix_vld
);

    logic             take;
    phase_e           phase;
    group_t           grp;
    logic             grp_done;
    logic [OUT_W-1:0] pixels;

    raw10_phase_ctl u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_vld   (word_vld),
        .frame_sync (frame_sync),
        .take       (take),
        .phase      (phase)
    );

    raw10_byte_gather u_gather (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .take       (take),
        .phase      (phase),
        .word       (word_in),
        .grp        (grp),
        .grp_done   (grp_done)
    );

    raw10_pixel_unpack u_unpack (
        .grp    (grp),
        .pixels (pixels)
    );

    // Register the rebuilt pixels; hold the last group between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out <= '0;
            pix_vld <= 1'b0;
        end else begin
            pix_vld <= grp_done;
            if (grp_done) begin
                pix_out <= pixels;
            end
        end
    end

endmodule

// File: rtl/raw10_depack_checker.sv
// Module: raw10_depack_checker
// Port-level properties of the depacker, attached with bind below.
// Keeps its own five-word counter to predict strobe timing.
module raw10_depack_checker
    import raw10_depack_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              word_vld,
    input logic              frame_sync,
    input logic [OUT_W-1:0]  pix_out,
    input logic              pix_vld
);

    logic [2:0] cnt;
    logic       exp_pulse;

    // Independent count of accepted words within the cycle, and the predicted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= 3'd0;
            exp_pulse <= 1'b0;
        end else begin
            exp_pulse <= word_vld && !frame_sync && ((cnt == 3'd2) || (cnt == 3'd4));
            if (frame_sync) begin
                cnt <= 3'd0;
            end else if (word_vld) begin
                cnt <= (cnt == 3'd4) ? 3'd0 : cnt + 3'd1;
            end
        end
    end

    // R2 and R3: strobes only after the 3rd and 5th word of a cycle.
    p_strobe_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld == exp_pulse)
        else $error("p_strobe_timing_r2");

    // R9: a strobe always follows an accepted word.
    p_needs_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |-> $past(word_vld && !frame_sync))
        else $error("p_needs_word_r9");

    // R7: the cycle after a sync never strobes.
    p_sync_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> !pix_vld)
        else $error("p_sync_quiet_r7");

    // R8: no back-to-back strobes.
    p_no_adjacent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> !pix_vld)
        else $error("p_no_adjacent_r8");

    // R8: output held while not strobing.
    p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |-> $stable(pix_out))
        else $error("p_hold_out_r8");

endmodule

bind raw10_depack_top raw10_depack_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_vld   (word_vld),
    .frame_sync (frame_sync),
    .pix_out    (pix_out),
    .pix_vld    (pix_vld)
);

// File: tb/raw10_depack_top_test.sv
`timescale 1ns/1ps
module raw10_depack_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] word_in = '0;
    logic        word_vld = 1'b0;
    logic        frame_sync = 1'b0;
    logic [39:0] pix_out;
    logic        pix_vld;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    logic        mon_on = 1'b0;
    logic [39:0] exp_q[$];
    logic [7:0]  pend[$];
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    raw10_depack_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_in    (word_in),
        .word_vld   (word_vld),
        .frame_sync (frame_sync),
        .pix_out    (pix_out),
        .pix_vld    (pix_vld)
    );

    // R5: expected layout computed from the group bytes
    function automatic logic [39:0] grp_pixels(input logic [7:0] b0, b1, b2, b3, b4);
        grp_pixels = {b3, b4[7:6], b2, b4[5:4], b1, b4[3:2], b0, b4[1:0]};
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic model_byte(input logic [7:0] b);
        pend.push_back(b);
        if (pend.size() == 5) begin
            exp_q.push_back(grp_pixels(pend[0], pend[1], pend[2], pend[3], pend[4]));
            pend.delete();
        end
    endtask

    // Driver: one valid word; R4 low byte goes first into the model
    task automatic put_word(input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk);
        word_in    = {hi, lo};
        word_vld   = 1'b1;
        frame_sync = 1'b0;
        model_byte(lo);
        model_byte(hi);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            word_vld   = 1'b0;
            frame_sync = 1'b0;
            word_in    = 16'hDEAD;
        end
    endtask

    // R7: sync, optionally with a word that must be discarded
    task automatic do_sync(input logic with_word);
        @(negedge clk);
        frame_sync = 1'b1;
        word_vld   = with_word;
        word_in    = 16'hA55A;
        pend.delete();
    endtask

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops expected groups on each strobe, checks holding otherwise
    logic [39:0] last_out = '0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (pix_vld === 1'b1) begin
                if (exp_q.size() == 0) begin
                    check("R2/R3/R9 unexpected strobe", pix_out, 40'hX);
                end else begin
                    check("R2/R3/R5 group", pix_out, exp_q.pop_front());
                end
            end else begin
                check("R6/R8 hold", pix_out, last_out);
            end
            last_out = pix_out;
        end
    end

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 reset pix_out", pix_out, 40'h0);
        check("R1 reset pix_vld", {39'h0, pix_vld}, 40'h0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R2 R3 R4: one back-to-back cycle of five words
        put_word(8'h11, 8'h22);
        put_word(8'h33, 8'h44);
        put_word(8'hE4, 8'h55);
        put_word(8'h66, 8'h77);
        put_word(8'h88, 8'h1B);
        idle(3);

        // R5: low-bit field extremes
        put_word(8'h00, 8'hFF);
        put_word(8'h80, 8'h01);
        put_word(8'hFF, 8'hFF);
        put_word(8'h00, 8'h00);
        put_word(8'h00, 8'h00);
        idle(2);

        // R6: gaps at every phase position
        for (int w = 0; w < 40; w++) begin
            seed = next_rand(seed);
            put_word(seed[7:0], seed[15:8]);
            if (seed[18:16] < 3) idle(int'(seed[20:19]) + 1);
        end
        idle(3);

        // R7: sync in mid-group, then a fresh cycle
        put_word(8'h01, 8'h02);
        put_word(8'h03, 8'h04);
        do_sync(1'b0);
        idle(1);
        for (int w = 0; w < 10; w++) begin
            seed = next_rand(seed);
            put_word(seed[7:0], seed[15:8]);
        end
        idle(2);

        // R7: sync after the residual byte, with a discarded word
        put_word(8'h10, 8'h20);
        put_word(8'h30, 8'h40);
        put_word(8'h50, 8'h60);
        do_sync(1'b1);
        put_word(8'hC1, 8'hC2);
        put_word(8'hC3, 8'hC4);
        put_word(8'h9C, 8'hD1);
        put_word(8'hD2, 8'hD3);
        put_word(8'hD4, 8'h36);
        idle(3);

        // R9: long stream without gaps
        for (int w = 0; w < 100; w++) begin
            seed = next_rand(seed);
            put_word(seed[23:16], seed[31:24]);
        end
        idle(4);

        // All expected groups must have appeared
        check("R2/R3 pending groups", 40'(exp_q.size()), 40'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule